// File: doc/BRIEF.md
# Paged Segment Address Translator

This block turns a logical address made of a segment number and a segment offset into a physical address. Each segment has its own page table. The translation takes two reads from one shared table memory. The first read fetches the segment descriptor, which holds the segment length and the base address of that segment's page table. The offset must be strictly below the length. Only after that test passes is the offset split into a page index and an in-page offset. The second read uses the page index to fetch the page entry, which holds a frame number and a present flag. The physical address is the frame number followed by the in-page offset. Requests that fail return one of three distinct fault codes instead of an address:

- a segment number past the configured count, raised before any memory read;
- a length violation, raised after the first read;
- a missing page, raised after the second read.

The controller is a six-state machine:

- `ST_IDLE` accepts a request. It goes to `ST_SEG_RD`, or straight to `ST_RESP` when the segment number is out of range.
- `ST_SEG_RD` issues the descriptor read. It goes to `ST_SEG_CHK`.
- `ST_SEG_CHK` tests the offset against the returned length. It goes to `ST_PG_RD` when the offset passes, or to `ST_RESP` when it fails.
- `ST_PG_RD` issues the page-entry read. It goes to `ST_PG_CHK`.
- `ST_PG_CHK` tests the present flag and forms the address. It goes to `ST_RESP`.
- `ST_RESP` presents the result for one cycle. It returns to `ST_IDLE`.

The table memory returns read data on the clock edge after the cycle in which `tbl_rd_en` is high.

Top module: `pageseg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `tbl_rd_en` is 0.
- R2: A request whose segment number is at least `NUM_SEGS` (16 by default) responds with status 2 (segment trap) and a physical address of 0. It makes no table read.
- R3: For an in-range segment, the first read goes to address `SEG_TBL_BASE + segment` in the cycle after acceptance. The descriptor holds the length in bits [26:10] (17 bits) and the page-table base in bits [9:0].
- R4: An offset greater than or equal to the segment length responds with status 1 (length trap) and address 0. Exactly one read is made.
- R5: For a legal offset, the page index is offset bits [15:10] and the in-page offset is bits [9:0]. The second read goes to (page-table base + page index) modulo 1024.
- R6: A page entry with bit 31 set responds with status 0, and the physical address is entry bits [7:0] concatenated with the in-page offset (18 bits).
- R7: A page entry with bit 31 clear responds with status 3 (page fault) and address 0.
- R8: `rsp_valid` is high for exactly one cycle. Counted from the accepting edge, it comes 1 cycle later for a segment trap, 3 for a length trap, and 5 for a completed lookup or page fault. `req_ready` is high only while idle.
- R9: Segment 15 of length 5096, with page 3 held in frame 12, translates offset 3921 to physical address 13137.
- R10: An offset equal to length minus 1 is legal and an offset equal to the length traps. A segment of length 0 traps every offset, and a length of 65536 admits every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Translator idle, request accepted when valid |
| req_seg | input | SEG_W (5) | Segment number |
| req_off | input | OFF_W (16) | Offset within the segment |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_status | output | 2 | 0 ok, 1 length trap, 2 segment trap, 3 page fault |
| rsp_paddr | output | FRAME_W+PAGE_W (18) | Physical address, 0 on any fault |
| tbl_rd_en | output | 1 | Table memory read strobe |
| tbl_rd_addr | output | TBL_AW (10) | Table memory word address |
| tbl_rd_data | input | TBL_DW (32) | Table memory data, one cycle after the strobe |

## Verification
The bound checker watches every cycle for the following properties:
- a segment trap answers in the next cycle with no read;
- the descriptor read address follows the accepted segment number;
- a length trap is preceded by exactly one read two cycles earlier;
- fault responses carry a zero address;
- successful responses keep the accepted in-page offset;
- the response is a single-cycle pulse that never overlaps readiness.

Two things can only be shown by the bench's sweep over all 32 segment numbers and their boundary offsets, using a memory model with wrap-around page-table bases and scattered absent pages. The first is the numeric result of the length comparison. The second is the frame chosen by the page-index arithmetic.

// File: rtl/pageseg_pkg.sv
package pageseg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEG_RD  = 3'd1,
        ST_SEG_CHK = 3'd2,
        ST_PG_RD   = 3'd3,
        ST_PG_CHK  = 3'd4,
        ST_RESP    = 3'd5
    } xl_state_e;

    typedef enum logic [1:0] {
        XS_OK         = 2'd0,
        XS_LEN_TRAP   = 2'd1,
        XS_SEG_TRAP   = 2'd2,
        XS_PAGE_FAULT = 2'd3
    } xl_status_e;

endpackage

// File: rtl/pageseg_bound_chk.sv
module pageseg_bound_chk #(
    parameter int SEG_W    = 5,
    parameter int OFF_W    = 16,
    parameter int NUM_SEGS = 16
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W:0]   seg_len,
    output logic             seg_in_range,
    output logic             off_in_range
);
    localparam logic [SEG_W:0] SEG_LIMIT = (SEG_W+1)'(NUM_SEGS);

    // segment number must lie below the configured count
    assign seg_in_range = {1'b0, seg} < SEG_LIMIT;
    // offset must be strictly below the segment length
    assign off_in_range = {1'b0, off} < seg_len;
endmodule

// File: rtl/pageseg_addr_form.sv
module pageseg_addr_form #(
    parameter int SEG_W        = 5,
    parameter int OFF_W        = 16,
    parameter int PAGE_W       = 10,
    parameter int FRAME_W      = 8,
    parameter int TBL_AW       = 10,
    parameter int SEG_TBL_BASE = 0
) (
    input  logic [SEG_W-1:0]          seg,
    input  logic [OFF_W-1:0]          off,
    input  logic [TBL_AW-1:0]         pt_base,
    input  logic [FRAME_W-1:0]        frame,
    output logic [TBL_AW-1:0]         seg_ent_addr,
    output logic [TBL_AW-1:0]         pte_addr,
    output logic [FRAME_W+PAGE_W-1:0] paddr
);
    localparam int PIDX_W = OFF_W - PAGE_W;
    localparam logic [TBL_AW-1:0] SEG_BASE = TBL_AW'(SEG_TBL_BASE);

    logic [PIDX_W-1:0] page_idx;
    logic [PAGE_W-1:0] in_page;

    assign page_idx = off[OFF_W-1:PAGE_W];
    assign in_page  = off[PAGE_W-1:0];

    assign seg_ent_addr = SEG_BASE + TBL_AW'(seg);

    generate
        if (PIDX_W >= TBL_AW) begin : g_idx_trunc
            assign pte_addr = pt_base + page_idx[TBL_AW-1:0];
        end else begin : g_idx_ext
            assign pte_addr = pt_base + {{(TBL_AW-PIDX_W){1'b0}}, page_idx};
        end
    endgenerate

    assign paddr = {frame, in_page};
endmodule

// File: rtl/pageseg_ctrl.sv
module pageseg_ctrl
    import pageseg_pkg::*;
#(
    parameter int SEG_W   = 5,
    parameter int OFF_W   = 16,
    parameter int PADDR_W = 18,
    parameter int TBL_AW  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic               seg_in_range,
    input  logic               off_in_range,
    input  logic               pte_valid,
    input  logic [TBL_AW-1:0]  rd_pt_base,
    input  logic [TBL_AW-1:0]  seg_ent_addr,
    input  logic [TBL_AW-1:0]  pte_addr,
    input  logic [PADDR_W-1:0] paddr_calc,
    output logic [SEG_W-1:0]   seg_q,
    output logic [OFF_W-1:0]   off_q,
    output logic [TBL_AW-1:0]  pt_base_q,
    output logic               req_ready,
    output logic               rd_en,
    output logic [TBL_AW-1:0]  rd_addr,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [PADDR_W-1:0] rsp_paddr
);
    xl_state_e   state, state_nxt;
    xl_status_e  status_q;
    logic [PADDR_W-1:0] paddr_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nxt = seg_in_range ? ST_SEG_RD : ST_RESP;
            ST_SEG_RD:  state_nxt = ST_SEG_CHK;
            ST_SEG_CHK: state_nxt = off_in_range ? ST_PG_RD : ST_RESP;
            ST_PG_RD:   state_nxt = ST_PG_CHK;
            ST_PG_CHK:  state_nxt = ST_RESP;
            ST_RESP:    state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // captured request and result
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q     <= '0;
            off_q     <= '0;
            pt_base_q <= '0;
            status_q  <= XS_OK;
            paddr_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        seg_q    <= req_seg;
                        off_q    <= req_off;
                        paddr_q  <= '0;
                        status_q <= seg_in_range ? XS_OK : XS_SEG_TRAP;
                    end
                end
                ST_SEG_CHK: begin
                    pt_base_q <= rd_pt_base;
                    if (!off_in_range) status_q <= XS_LEN_TRAP;
                end
                ST_PG_CHK: begin
                    if (pte_valid) paddr_q  <= paddr_calc;
                    else           status_q <= XS_PAGE_FAULT;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        rd_en     = 1'b0;
        rd_addr   = '0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_SEG_RD: begin
                rd_en   = 1'b1;
                rd_addr = seg_ent_addr;
            end
            ST_PG_RD: begin
                rd_en   = 1'b1;
                rd_addr = pte_addr;
            end
            ST_RESP:   rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_status = status_q;
    assign rsp_paddr  = paddr_q;
endmodule

// File: rtl/pageseg_xlate.sv
module pageseg_xlate #(
    parameter int SEG_W        = 5,
    parameter int OFF_W        = 16,
    parameter int PAGE_W       = 10,
    parameter int FRAME_W      = 8,
    parameter int TBL_AW       = 10,
    parameter int TBL_DW       = 32,
    parameter int NUM_SEGS     = 16,
    parameter int SEG_TBL_BASE = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [SEG_W-1:0]          req_seg,
    input  logic [OFF_W-1:0]          req_off,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_status,
    output logic [FRAME_W+PAGE_W-1:0] rsp_paddr,
    output logic                      tbl_rd_en,
    output logic [TBL_AW-1:0]         tbl_rd_addr,
    input  logic [TBL_DW-1:0]         tbl_rd_data
);
    localparam int PADDR_W = FRAME_W + PAGE_W;
    localparam int LEN_W   = OFF_W + 1;

    // descriptor and page entry fields
    logic [LEN_W-1:0]   d_len;
    logic [TBL_AW-1:0]  d_pt_base;
    logic               e_present;
    logic [FRAME_W-1:0] e_frame;
    logic               unused_rd_bits;

    assign d_len          = tbl_rd_data[TBL_AW+LEN_W-1:TBL_AW];
    assign d_pt_base      = tbl_rd_data[TBL_AW-1:0];
    assign e_present      = tbl_rd_data[TBL_DW-1];
    assign e_frame        = tbl_rd_data[FRAME_W-1:0];
    assign unused_rd_bits = ^tbl_rd_data;

    logic [SEG_W-1:0]   seg_q;
    logic [OFF_W-1:0]   off_q;
    logic [TBL_AW-1:0]  pt_base_q;
    logic               seg_in_range, off_in_range;
    logic [TBL_AW-1:0]  seg_ent_addr, pte_addr;
    logic [PADDR_W-1:0] paddr_calc;

    pageseg_bound_chk #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .NUM_SEGS(NUM_SEGS)
    ) bound_i (
        .seg          (req_seg),
        .off          (off_q),
        .seg_len      (d_len),
        .seg_in_range (seg_in_range),
        .off_in_range (off_in_range)
    );

    pageseg_addr_form #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W),
        .TBL_AW(TBL_AW), .SEG_TBL_BASE(SEG_TBL_BASE)
    ) form_i (
        .seg          (seg_q),
        .off          (off_q),
        .pt_base      (pt_base_q),
        .frame        (e_frame),
        .seg_ent_addr (seg_ent_addr),
        .pte_addr     (pte_addr),
        .paddr        (paddr_calc)
    );

    pageseg_ctrl #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PADDR_W(PADDR_W), .TBL_AW(TBL_AW)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_seg      (req_seg),
        .req_off      (req_off),
        .seg_in_range (seg_in_range),
        .off_in_range (off_in_range),
        .pte_valid    (e_present),
        .rd_pt_base   (d_pt_base),
        .seg_ent_addr (seg_ent_addr),
        .pte_addr     (pte_addr),
        .paddr_calc   (paddr_calc),
        .seg_q        (seg_q),
        .off_q        (off_q),
        .pt_base_q    (pt_base_q),
        .req_ready    (req_ready),
        .rd_en        (tbl_rd_en),
        .rd_addr      (tbl_rd_addr),
        .rsp_valid    (rsp_valid),
        .rsp_status   (rsp_status),
        .rsp_paddr    (rsp_paddr)
    );
endmodule

// File: rtl/pageseg_xlate_chk.sv
module pageseg_xlate_chk #(
    parameter int SEG_W        = 5,
    parameter int OFF_W        = 16,
    parameter int PAGE_W       = 10,
    parameter int FRAME_W      = 8,
    parameter int TBL_AW       = 10,
    parameter int TBL_DW       = 32,
    parameter int NUM_SEGS     = 16,
    parameter int SEG_TBL_BASE = 0
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [SEG_W-1:0]          req_seg,
    input logic [OFF_W-1:0]          req_off,
    input logic                      rsp_valid,
    input logic [1:0]                rsp_status,
    input logic [FRAME_W+PAGE_W-1:0] rsp_paddr,
    input logic                      tbl_rd_en,
    input logic [TBL_AW-1:0]         tbl_rd_addr,
    input logic [TBL_DW-1:0]         tbl_rd_data
);
    localparam logic [SEG_W:0]  SEG_LIMIT = (SEG_W+1)'(NUM_SEGS);
    localparam logic [TBL_AW-1:0] SEG_BASE = TBL_AW'(SEG_TBL_BASE);

    logic              accept;
    logic              seg_high;
    logic [OFF_W-1:0]  off_cap;
    logic              unused_chk;

    assign accept     = req_valid && req_ready;
    assign seg_high   = {1'b0, req_seg} >= SEG_LIMIT;
    assign unused_chk = ^{tbl_rd_data, off_cap[OFF_W-1:PAGE_W]};

    always_ff @(posedge clk) begin
        if (rst)         off_cap <= '0;
        else if (accept) off_cap <= req_off;
    end

    // R2: out-of-range segment answers next cycle, no read
    a_r2_segtrap_no_read: assert property (@(posedge clk) disable iff (rst)
        (accept && seg_high) |=> (rsp_valid && rsp_status == 2'd2 && !tbl_rd_en));

    // R3: descriptor read address follows the accepted segment
    a_r3_desc_addr: assert property (@(posedge clk) disable iff (rst)
        (accept && !seg_high) |=>
            (tbl_rd_en && tbl_rd_addr == SEG_BASE + TBL_AW'($past(req_seg))));

    // R4: a length trap follows exactly one read
    a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd1) |-> ($past(tbl_rd_en, 2) && !$past(tbl_rd_en, 1)));

    // R6: a successful address keeps the in-page offset
    a_r6_inpage_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |-> (rsp_paddr[PAGE_W-1:0] == off_cap[PAGE_W-1:0]));

    // R7: faults carry no address
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

    // R8: response is a one-cycle pulse, then idle
    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8: no readiness while responding or reading
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || tbl_rd_en) |-> !req_ready);
endmodule

bind pageseg_xlate pageseg_xlate_chk #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W),
    .TBL_AW(TBL_AW), .TBL_DW(TBL_DW), .NUM_SEGS(NUM_SEGS), .SEG_TBL_BASE(SEG_TBL_BASE)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_seg     (req_seg),
    .req_off     (req_off),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_paddr   (rsp_paddr),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_rd_addr (tbl_rd_addr),
    .tbl_rd_data (tbl_rd_data)
);

// File: tb/pageseg_xlate_tb_top.sv
module pageseg_xlate_tb_top;
    localparam int SEG_W = 5, OFF_W = 16, PAGE_W = 10, FRAME_W = 8;
    localparam int TBL_AW = 10, TBL_DW = 32, NUM_SEGS = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic rsp_valid;
    logic [1:0] rsp_status;
    logic [FRAME_W+PAGE_W-1:0] rsp_paddr;
    logic tbl_rd_en;
    logic [TBL_AW-1:0] tbl_rd_addr;
    logic [TBL_DW-1:0] tbl_rd_data = '0;

    logic [31:0] mem [0:1023];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];

    pageseg_xlate dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .tbl_rd_en(tbl_rd_en),
        .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data)
    );

    function automatic int seg_len(input int s);
        if (s == 0)  return 0;
        if (s == 1)  return 65536;
        if (s == 15) return 5096;
        return (s * 4099 + 17) % 65536;
    endfunction

    function automatic int seg_ptb(input int s);
        return (s * 61 + 32) % 1024;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic xact(input int s, input int off);
        int e_st, e_lat, e_reads, e_a1, e_a2, e_pa;
        int len, ptb, n, reads, a1, a2, lat, st, pa;
        logic [31:0] d, p;
        string tag;
        e_a1 = 0; e_a2 = 0; e_pa = 0;
        if (s >= NUM_SEGS) begin
            e_st = 2; e_lat = 1; e_reads = 0; tag = "R2";
        end else begin
            d = mem[s];
            len = int'(d[26:10]);
            ptb = int'(d[9:0]);
            e_a1 = s;
            if (off >= len) begin
                e_st = 1; e_lat = 3; e_reads = 1; tag = "R4/R10";
            end else begin
                e_a2 = (ptb + (off >> 10)) % 1024;
                p = mem[e_a2];
                e_lat = 5; e_reads = 2;
                if (p[31]) begin
                    e_st = 0; e_pa = int'(p[7:0]) * 1024 + (off % 1024); tag = "R6";
                end else begin
                    e_st = 3; tag = "R7";
                end
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_seg   = SEG_W'(s);
        req_off   = OFF_W'(off);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; reads = 0; a1 = -1; a2 = -1; lat = -1; st = -1; pa = -1;
        forever begin
            if (tbl_rd_en) begin
                if (reads == 0) a1 = int'(tbl_rd_addr);
                else            a2 = int'(tbl_rd_addr);
                reads++;
            end
            if (rsp_valid) begin
                lat = n; st = int'(rsp_status); pa = int'(rsp_paddr);
                break;
            end
            n++;
            if (n > 8) break;
            @(negedge clk);
        end
        check(lat == e_lat, "R8 latency", lat, e_lat);
        check(reads == e_reads, "R3 read count", reads, e_reads);
        if (e_reads >= 1) check(a1 == e_a1, "R3 descriptor address", a1, e_a1);
        if (e_reads == 2) check(a2 == e_a2, "R5 page entry address", a2, e_a2);
        check(st == e_st, {tag, " status"}, st, e_st);
        check(pa == e_pa, {tag, " paddr"}, pa, e_pa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin
            if (a % 7 == 3) mem[a] = {1'b0, 23'(a * 977), 8'(a * 13 + 5)};
            else            mem[a] = {1'b1, 23'(a * 977), 8'(a * 13 + 5)};
        end
        for (int s = 0; s < NUM_SEGS; s++)
            mem[s] = {5'(s + 9), 17'(seg_len(s)), 10'(seg_ptb(s))};
        mem[seg_ptb(15) + 3] = {1'b1, 23'd0, 8'd12};

        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        check(tbl_rd_en == 1'b0, "R1 rd_en in reset", tbl_rd_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && tbl_rd_en == 1'b0,
              "R1 idle after reset", {req_ready, rsp_valid, tbl_rd_en}, 3'b100);

        // R9 worked example: (15,3921) -> 13137
        xact(15, 3921);
        check(rsp_paddr == 18'd13137, "R9 example address", rsp_paddr, 13137);

        // R10 boundaries
        xact(15, 5095);
        xact(15, 5096);
        xact(0, 0);
        xact(1, 65535);

        // sweep over every segment number
        for (int s = 0; s < 32; s++) begin
            int len;
            len = (s < NUM_SEGS) ? seg_len(s) : 100;
            xact(s, 0);
            xact(s, 1);
            xact(s, 1023);
            xact(s, 1024);
            xact(s, 65535);
            if (len > 0 && len <= 65536) xact(s, len - 1);
            if (len < 65536) xact(s, len);
            if (len + 1 < 65536) xact(s, len + 1);
            for (int k = 0; k < 14; k++) begin
                if (s < NUM_SEGS) xact(s, (s * 7919 + k * 12347) % ((len > 0 && len <= 65536) ? len : 65536));
                else if (k < 2) xact(s, k * 30011);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule